// File: doc/BRIEF.md
# Programmable AND-Plane Logic Array with Registered Macrocells

This block is a soft model of a small programmable logic array. It has a programmable AND plane and a hard-wired OR grouping. Each product term is the AND of any chosen subset of literals. A literal is the true or inverted form of an external input, or of a fed-back output. Each output ORs a private group of product terms, so no product term is shared between outputs.

Each output then passes through a macrocell. The macrocell can invert the sum, and it drives out either that value directly or the value held in a flip-flop. Registered outputs feed back into the AND plane as present state, so one array can implement a small state machine. Combinational outputs also feed back. This lets a function that needs more terms than one group offers be spread over several outputs.

The whole programming image arrives on a parallel configuration bus. It is captured on the clock edge where the load strobe is high.

Top module: `pal_core`

## Requirements
- R1: A product term is the AND of its selected literals. Term t uses bits `cfg_plane_i[t*24 + 2k]`, which selects literal k true, and `cfg_plane_i[t*24 + 2k + 1]`, which selects literal k inverted. Literal k is `in_i[k]` for k < 8 and `out_o[k-8]` for k >= 8.
- R2: A product term with no selected literal evaluates to 0.
- R3: A product term that selects both the true and the inverted form of any literal evaluates to 0.
- R4: Output o ORs exactly terms 4*o to 4*o+3. A term in another output's group never affects output o.
- R5: When `cfg_pol_i[o]` = 1, the OR result of output o is inverted before the macrocell. When it is 0, the result passes unchanged.
- R6: When `cfg_regm_i[o]` = 1 (registered), `out_o[o]` changes only at a clock edge. It then shows the polarity-corrected sum as it stood just before that edge.
- R7: When `cfg_regm_i[o]` = 0 (combinational), `out_o[o]` shows the polarity-corrected sum of the current inputs in the same cycle.
- R8: Output values feed back as literals. Registered outputs feed back their flip-flop value and combinational outputs their live value. An acyclic chain of combinational outputs settles within the same cycle.
- R9: A synchronous active-high reset clears every output flip-flop and the whole stored configuration, so that `out_o` reads 0 in the cycle after reset.
- R10: The configuration bus is captured on the edge where `cfg_valid_i` = 1 and takes effect from that edge on. Changes to the bus without the strobe have no effect.
- R11: Two registered outputs with feedback-only terms can be programmed as a 2-bit counter. `out_o[1:0]` then steps 0, 1, 2, 3, 0 on successive edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_i | input | 8 | External inputs to the AND plane |
| cfg_valid_i | input | 1 | Load strobe for the configuration bus |
| cfg_plane_i | input | 384 | Literal-select bits, 24 per term, 16 terms |
| cfg_pol_i | input | 4 | Per-output inversion select |
| cfg_regm_i | input | 4 | Per-output registered (1) or combinational (0) select |
| out_o | output | 4 | Macrocell outputs, also fed back as literals |

## Verification
Inputs are driven just after the falling edge. Combinational outputs are due in that same cycle, so they are compared one nanosecond later, before the next rising edge. Registered outputs are due one rising edge after the inputs that produced them, and a new configuration counts from the edge that saw the strobe. The bench reference model advances its flip-flop image and its active configuration only after each comparison, which keeps every check aligned to the edge that produces its value.

// File: rtl/pal_pkg.sv
package pal_pkg;
    parameter int unsigned DEF_NUM_IN  = 8;
    parameter int unsigned DEF_NUM_OUT = 4;
    parameter int unsigned DEF_TPO     = 4;

    typedef enum logic {
        MC_COMB = 1'b0,
        MC_REG  = 1'b1
    } mc_mode_e;
endpackage

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
    parameter int unsigned NUM_LIT   = 12,
    parameter int unsigned NUM_TERMS = 16
) (
    input  logic [NUM_LIT-1:0]             lits_i,
    input  logic [NUM_TERMS*2*NUM_LIT-1:0] plane_i,
    output logic [NUM_TERMS-1:0]           terms_o
);
    localparam int unsigned SEL_W = 2 * NUM_LIT;

    logic [SEL_W-1:0] lit_pair;

    for (genvar k = 0; k < NUM_LIT; k++) begin : g_pair
        assign lit_pair[2*k]   = lits_i[k];
        assign lit_pair[2*k+1] = ~lits_i[k];
    end

    for (genvar t = 0; t < NUM_TERMS; t++) begin : g_term
        logic [SEL_W-1:0] sel;
        assign sel = plane_i[t*SEL_W +: SEL_W];
        // empty selection must never assert; a contradictory pair fails the match
        assign terms_o[t] = (|sel) && ((sel & ~lit_pair) == '0);
    end
endmodule

// File: rtl/pal_or_fixed.sv
module pal_or_fixed #(
    parameter int unsigned NUM_OUT = 4,
    parameter int unsigned TPO     = 4
) (
    input  logic [NUM_OUT*TPO-1:0] terms_i,
    output logic [NUM_OUT-1:0]     sums_o
);
    for (genvar o = 0; o < NUM_OUT; o++) begin : g_sum
        assign sums_o[o] = |terms_i[o*TPO +: TPO];
    end
endmodule

// File: rtl/pal_eval_pass.sv
module pal_eval_pass #(
    parameter int unsigned NUM_IN  = 8,
    parameter int unsigned NUM_OUT = 4,
    parameter int unsigned TPO     = 4
) (
    input  logic [NUM_IN-1:0]                            in_i,
    input  logic [NUM_OUT-1:0]                           fb_i,
    input  logic [NUM_OUT*TPO*2*(NUM_IN+NUM_OUT)-1:0]    plane_i,
    input  logic [NUM_OUT-1:0]                           pol_i,
    output logic [NUM_OUT*TPO-1:0]                       terms_o,
    output logic [NUM_OUT-1:0]                           val_o
);
    localparam int unsigned NUM_LIT   = NUM_IN + NUM_OUT;
    localparam int unsigned NUM_TERMS = NUM_OUT * TPO;

    logic [NUM_OUT-1:0] sums;

    pal_and_plane #(
        .NUM_LIT   (NUM_LIT),
        .NUM_TERMS (NUM_TERMS)
    ) u_and (
        .lits_i  ({fb_i, in_i}),
        .plane_i (plane_i),
        .terms_o (terms_o)
    );

    pal_or_fixed #(
        .NUM_OUT (NUM_OUT),
        .TPO     (TPO)
    ) u_or (
        .terms_i (terms_o),
        .sums_o  (sums)
    );

    assign val_o = sums ^ pol_i;
endmodule

// File: rtl/pal_core.sv
module pal_core #(
    parameter int unsigned NUM_IN  = pal_pkg::DEF_NUM_IN,
    parameter int unsigned NUM_OUT = pal_pkg::DEF_NUM_OUT,
    parameter int unsigned TPO     = pal_pkg::DEF_TPO
) (
    input  logic                                         clk,
    input  logic                                         rst,
    input  logic [NUM_IN-1:0]                            in_i,
    input  logic                                         cfg_valid_i,
    input  logic [NUM_OUT*TPO*2*(NUM_IN+NUM_OUT)-1:0]    cfg_plane_i,
    input  logic [NUM_OUT-1:0]                           cfg_pol_i,
    input  logic [NUM_OUT-1:0]                           cfg_regm_i,
    output logic [NUM_OUT-1:0]                           out_o
);
    localparam int unsigned NUM_LIT   = NUM_IN + NUM_OUT;
    localparam int unsigned SEL_W     = 2 * NUM_LIT;
    localparam int unsigned NUM_TERMS = NUM_OUT * TPO;
    localparam int unsigned PLANE_W   = NUM_TERMS * SEL_W;
    // one pass per combinational chain level, plus one for registered next state
    localparam int unsigned PASSES    = NUM_OUT + 1;
    localparam logic [SEL_W-1:0] EVEN_MASK = {NUM_LIT{2'b01}};

    typedef struct packed {
        logic [PLANE_W-1:0] plane;
        logic [NUM_OUT-1:0] pol;
        logic [NUM_OUT-1:0] regm;
        logic [NUM_OUT-1:0] q;
    } state_t;

    state_t state_d, state_q;

    logic [NUM_OUT-1:0]   fb_chain  [PASSES+1];
    logic [NUM_OUT-1:0]   val_pass  [PASSES];
    logic [NUM_TERMS-1:0] term_pass [PASSES];
    logic [NUM_OUT-1:0]   reg_view;

    // registered outputs present their flop; combinational ones start unresolved
    assign reg_view    = state_q.regm & state_q.q;
    assign fb_chain[0] = reg_view;

    for (genvar p = 0; p < PASSES; p++) begin : g_pass
        pal_eval_pass #(
            .NUM_IN  (NUM_IN),
            .NUM_OUT (NUM_OUT),
            .TPO     (TPO)
        ) u_pass (
            .in_i    (in_i),
            .fb_i    (fb_chain[p]),
            .plane_i (state_q.plane),
            .pol_i   (state_q.pol),
            .terms_o (term_pass[p]),
            .val_o   (val_pass[p])
        );
        assign fb_chain[p+1] = reg_view | (~state_q.regm & val_pass[p]);
    end

    assign out_o = fb_chain[PASSES];

    always_comb begin
        state_d   = state_q;
        state_d.q = val_pass[PASSES-1];
        if (cfg_valid_i) begin
            state_d.plane = cfg_plane_i;
            state_d.pol   = cfg_pol_i;
            state_d.regm  = cfg_regm_i;
        end
        if (rst) begin
            state_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    // ---------------- assertions ----------------
    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_o == '0));

    assert_cfg_capture_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_valid_i)) |->
            (state_q.pol == $past(cfg_pol_i) && state_q.regm == $past(cfg_regm_i)));

    assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(cfg_valid_i)) |-> $stable(state_q.plane));

    for (genvar o = 0; o < NUM_OUT; o++) begin : g_chk_out
        assert_reg_out_R6: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(cfg_valid_i) && $past(state_q.regm[o]))
                |-> (out_o[o] == $past(val_pass[PASSES-1][o])));
    end

    for (genvar p = 0; p < PASSES; p++) begin : g_chk_pass
        for (genvar t = 0; t < NUM_TERMS; t++) begin : g_chk_term
            assert_empty_term_R2: assert property (@(posedge clk) disable iff (rst)
                (state_q.plane[t*SEL_W +: SEL_W] == '0) |-> !term_pass[p][t]);
            assert_conflict_term_R3: assert property (@(posedge clk) disable iff (rst)
                ((state_q.plane[t*SEL_W +: SEL_W]
                  & (state_q.plane[t*SEL_W +: SEL_W] >> 1) & EVEN_MASK) != '0)
                    |-> !term_pass[p][t]);
        end
    end
endmodule

// File: tb/tb_pal_core.sv
module tb_pal_core;
    localparam int NI = 8;
    localparam int NO = 4;
    localparam int TPO = 4;
    localparam int NL = NI + NO;
    localparam int SW = 2 * NL;
    localparam int NT = NO * TPO;
    localparam int PW = NT * SW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NI-1:0] in_i = '0;
    logic          cfg_valid_i = 1'b0;
    logic [PW-1:0] cfg_plane_i = '0;
    logic [NO-1:0] cfg_pol_i = '0;
    logic [NO-1:0] cfg_regm_i = '0;
    logic [NO-1:0] out_o;

    int checks = 0;
    int errors = 0;

    logic [PW-1:0] a_plane = '0;
    logic [NO-1:0] a_pol = '0;
    logic [NO-1:0] a_regm = '0;
    logic [NO-1:0] mq = '0;

    pal_core dut (
        .clk(clk), .rst(rst), .in_i(in_i), .cfg_valid_i(cfg_valid_i),
        .cfg_plane_i(cfg_plane_i), .cfg_pol_i(cfg_pol_i),
        .cfg_regm_i(cfg_regm_i), .out_o(out_o)
    );

    always #4 clk = ~clk;

    function automatic logic term_model(input int t, input logic [NI-1:0] x,
                                        input logic [NO-1:0] fb, input logic [PW-1:0] pl);
        logic any = 1'b0;
        logic ok = 1'b1;
        for (int k = 0; k < NL; k++) begin
            logic lit = (k < NI) ? x[k] : fb[k-NI];
            if (pl[t*SW + 2*k])   begin any = 1'b1; if (!lit) ok = 1'b0; end
            if (pl[t*SW + 2*k+1]) begin any = 1'b1; if (lit)  ok = 1'b0; end
        end
        return any & ok;
    endfunction

    // returns {next flop values, visible outputs}
    function automatic logic [2*NO-1:0] model(input logic [NI-1:0] x, input logic [NO-1:0] q,
                                              input logic [PW-1:0] pl, input logic [NO-1:0] pol,
                                              input logic [NO-1:0] regm);
        logic [NO-1:0] fb = regm & q;
        logic [NO-1:0] val = '0;
        for (int r = 0; r <= NO; r++) begin
            for (int o = 0; o < NO; o++) begin
                logic s = 1'b0;
                for (int j = 0; j < TPO; j++) s = s | term_model(o*TPO + j, x, fb, pl);
                val[o] = s ^ pol[o];
            end
            for (int o = 0; o < NO; o++) fb[o] = regm[o] ? q[o] : val[o];
        end
        return {val, fb};
    endfunction

    task automatic check(input string req, input logic [NO-1:0] act, input logic [NO-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic step(input logic [NI-1:0] x, input logic cv, input logic r, input string req);
        logic [2*NO-1:0] res;
        @(negedge clk);
        rst = r; in_i = x; cfg_valid_i = cv;
        #1;
        res = model(x, mq, a_plane, a_pol, a_regm);
        if (!r) check(req, out_o, res[NO-1:0]);
        if (r) begin
            mq = '0; a_plane = '0; a_pol = '0; a_regm = '0;
        end else begin
            mq = res[2*NO-1:NO];
            if (cv) begin a_plane = cfg_plane_i; a_pol = cfg_pol_i; a_regm = cfg_regm_i; end
        end
    endtask

    task automatic sel(input int t, input int k, input bit inv);
        cfg_plane_i[t*SW + 2*k + int'(inv)] = 1'b1;
    endtask

    task automatic clear_cfg();
        cfg_plane_i = '0; cfg_pol_i = '0; cfg_regm_i = '0;
    endtask

    initial begin
        #1600000;
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [NO-1:0] seq [5];
        void'($urandom(32'd20250));

        // reset state, with a junk bus and no strobe: R9, R10
        cfg_plane_i = '1; cfg_pol_i = '1; cfg_regm_i = '1;
        step(8'h00, 1'b0, 1'b1, "R9");
        step(8'hA5, 1'b0, 1'b0, "R9");
        check("R9 reset out", out_o, 4'b0000);
        step(8'h5A, 1'b0, 1'b0, "R10");
        check("R10 unstrobed bus ignored", out_o, 4'b0000);

        // empty terms with inversion: R2, R5
        clear_cfg(); cfg_pol_i = 4'b0001;
        step(8'h00, 1'b1, 1'b0, "R10");
        step(8'hFF, 1'b0, 1'b0, "R2");
        check("R2 empty terms give inverted 0", out_o, 4'b0001);

        // conflicting literal pair: R3
        clear_cfg(); sel(0, 0, 0); sel(0, 0, 1); sel(0, 1, 0);
        step(8'h00, 1'b1, 1'b0, "R10");
        step(8'h03, 1'b0, 1'b0, "R3");
        check("R3 conflict term in0=1", out_o, 4'b0000);
        step(8'h02, 1'b0, 1'b0, "R3");
        check("R3 conflict term in0=0", out_o, 4'b0000);

        // AND of literals: R1; polarity: R5; same-cycle comb: R7
        clear_cfg(); sel(0, 0, 0); sel(0, 1, 1); sel(0, 2, 0); cfg_pol_i = 4'b0010;
        sel(4, 5, 0);
        step(8'h00, 1'b1, 1'b0, "R10");
        step(8'h05, 1'b0, 1'b0, "R1");
        check("R1 term in0&~in1&in2 true", out_o, 4'b0011);
        step(8'h07, 1'b0, 1'b0, "R1");
        check("R1 term in0&~in1&in2 false", out_o, 4'b0010);
        step(8'h20, 1'b0, 1'b0, "R5");
        check("R5 inverted output 1, R7 same cycle", out_o, 4'b0000);

        // private groups: R4
        clear_cfg(); sel(4, 1, 0);
        step(8'h00, 1'b1, 1'b0, "R10");
        step(8'h02, 1'b0, 1'b0, "R4");
        check("R4 term 4 feeds output 1 only", out_o, 4'b0010);

        // registered timing: R6
        clear_cfg(); sel(0, 0, 0); cfg_regm_i = 4'b0001;
        step(8'h00, 1'b1, 1'b0, "R10");
        step(8'h01, 1'b0, 1'b0, "R6");
        check("R6 no change before edge", out_o, 4'b0000);
        step(8'h00, 1'b0, 1'b0, "R6");
        check("R6 value after edge", out_o, 4'b0001);

        // bus change without strobe keeps config: R10
        cfg_regm_i = 4'b0000; cfg_pol_i = 4'b1111;
        step(8'h00, 1'b0, 1'b0, "R10");
        check("R10 config held", out_o, 4'b0000);

        // combinational chain into a registered output: R8
        clear_cfg();
        sel(0, 0, 0); sel(0, 1, 0);
        sel(4, 8, 0); sel(4, 2, 0);
        sel(8, 9, 0); sel(9, 3, 0);
        sel(12, 10, 0);
        cfg_regm_i = 4'b1000;
        step(8'h00, 1'b1, 1'b0, "R10");
        step(8'h07, 1'b0, 1'b0, "R8");
        check("R8 chain settles same cycle", out_o, 4'b0111);
        step(8'h00, 1'b0, 1'b0, "R8");
        check("R8 registered feedback of chain", out_o, 4'b1000);

        // 2-bit counter: R11
        step(8'h00, 1'b0, 1'b1, "R9");
        clear_cfg();
        sel(0, 8, 1);
        sel(4, 9, 0); sel(4, 8, 1);
        sel(5, 9, 1); sel(5, 8, 0);
        cfg_regm_i = 4'b0011;
        step(8'h00, 1'b1, 1'b0, "R10");
        seq[0] = 4'd0; seq[1] = 4'd1; seq[2] = 4'd2; seq[3] = 4'd3; seq[4] = 4'd0;
        for (int i = 0; i < 5; i++) begin
            step(8'($urandom), 1'b0, 1'b0, "R11");
            check("R11 counter", out_o, seq[i]);
        end

        // random configurations and inputs: R1 R4 R5 R6 R7 R8
        for (int c = 0; c < 40; c++) begin
            for (int b = 0; b < PW; b++) cfg_plane_i[b] = (($urandom % 10) == 0);
            cfg_pol_i = 4'($urandom); cfg_regm_i = 4'($urandom);
            for (int o = 0; o < NO; o++) begin
                if (!cfg_regm_i[o]) begin
                    for (int j = 0; j < TPO; j++) begin
                        for (int m = o; m < NO; m++) begin
                            if (!cfg_regm_i[m]) begin
                                cfg_plane_i[(o*TPO+j)*SW + 2*(NI+m)]   = 1'b0;
                                cfg_plane_i[(o*TPO+j)*SW + 2*(NI+m)+1] = 1'b0;
                            end
                        end
                    end
                end
            end
            step(8'($urandom), 1'b1, (($urandom % 8) == 0), "R10 random load");
            for (int s = 0; s < 25; s++) step(8'($urandom), 1'b0, 1'b0, "R1 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule